// File: doc/BRIEF.md
# Dual-Port Byte DMA Transfer Engine

This block moves or scans bytes between two address ports, A and B. Each port holds an address counter and a small flag byte. The flag byte places the port in memory or I/O space, and it makes the address count up, count down or stay fixed. One control bit decides which port is read and which port is written. Two more control bits enable the write action and the search action separately. In search mode each fetched byte is compared with a pattern under a don't-care mask, and a hit stops the engine.

A start pulse latches the whole configuration, clears the status flags and rewinds the byte counter. The engine then works through the block. In continuous mode it runs until it stops. In byte mode it handles one byte for each service request. Every byte is one read strobe, followed by one write strobe when writing is enabled. A block ends when the length is used up or the counter wraps, or when a search hit occurs. When it stops, the engine can raise an interrupt whose vector may carry the cause of the stop.

Top module: `bdma_engine`

## Requirements
- R1: Control bit 2 set makes port A the source and port B the destination. Bit 2 clear swaps the two roles.
- R2: In a port flag byte, bit 3 set selects I/O space (bus_io=1) and bit 3 clear selects memory. Bit 5 set holds the address fixed. With bit 5 clear, bit 4 set adds one per step and bit 4 clear subtracts one per step.
- R3: The first byte after a start uses both start addresses unchanged. Every later byte steps both non-fixed addresses and then accesses the ports.
- R4: Control bit 0 enables the write to the destination and control bit 1 enables the search. A start with both bits clear leaves the engine idle, and no strobe is issued.
- R5: A fetched byte d is a hit when ((d XOR pattern) AND NOT mask) is zero, so mask bits at 1 are ignored. A hit with search enabled stops the engine after that byte and sets match_flag. The byte that hits is still written when writing is enabled.
- R6: Each byte adds one to a CW-bit counter that starts at zero. With a nonzero length L the block ends after L+1 bytes. With L=0 it ends after 2^CW bytes, when the counter wraps. The end sets end_flag and stops the engine.
- R7: With cont_mode=1 the bytes follow one another without a pause. With cont_mode=0 the engine waits and handles exactly one byte for each service_req it samples while waiting.
- R8: A byte is a one-cycle bus_rd, then a one-cycle bus_wr on the next cycle when writing is enabled. busy is high from the cycle after an arming start until the engine stops.
- R9: On a stop with irq_enable=1, irq_req rises if the matching cause is enabled (irq_ctl bit 0 for a hit, bit 1 for end of block). irq_req holds until the next start. With irq_enable=0 it never rises.
- R10: With irq_ctl bit 5 set, the vector is (irq_base AND 0xF9) plus 2 for a hit or plus 4 for end of block. With bit 5 clear, the vector is irq_base unchanged.
- R11: When a hit and an end of block are both enabled and occur on the same byte, the vector reports the hit.
- R12: match_flag and end_flag stay set until the next start, which clears them along with irq_req and irq_vec.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: latch configuration, clear status, arm |
| ctl | input | 8 | Bit 0 write enable, bit 1 search enable, bit 2 A is source |
| cont_mode | input | 1 | 1 continuous, 0 one byte per service request |
| flags_a | input | 8 | Port A flags: bit 3 I/O, bit 4 up, bit 5 hold |
| flags_b | input | 8 | Port B flags, same layout |
| addr_a | input | AW | Port A start address |
| addr_b | input | AW | Port B start address |
| blk_len | input | CW | Block length (0 means full counter range) |
| match_pat | input | DW | Search pattern |
| match_mask | input | DW | Search don't-care mask |
| irq_enable | input | 1 | Master interrupt enable |
| irq_ctl | input | 8 | Bit 0 hit cause, bit 1 end cause, bit 5 status in vector |
| irq_base | input | 8 | Base interrupt vector |
| service_req | input | 1 | Byte-mode request for one byte |
| bus_addr | output | AW | Access address |
| bus_io | output | 1 | 1 for I/O space, 0 for memory |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled at the end of bus_rd |
| busy | output | 1 | Engine armed or working |
| match_flag | output | 1 | Search hit seen |
| end_flag | output | 1 | Block length reached |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The start pulse is taken on one edge, and busy is high after that edge. In continuous mode every byte then takes three cycles: a wait cycle, the read cycle and the write cycle. The flags, irq_req and irq_vec change on the same edge that ends the last strobe, and busy falls on that edge too. The bench drives inputs and samples outputs on falling edges. After a start it waits until busy is low, and only then compares flags, vector and strobe tallies. In byte mode it waits a fixed four falling edges after each service pulse, which is enough for that single byte's read and write.

// File: rtl/bdma_pkg.sv
`timescale 1ns/1ps
package bdma_pkg;
   // control byte bit positions
   localparam int CTL_WR   = 0;
   localparam int CTL_SRCH = 1;
   localparam int CTL_ASRC = 2;
   // port flag bit positions
   localparam int PF_IO    = 3;
   localparam int PF_UP    = 4;
   localparam int PF_HOLD  = 5;
   // interrupt control bit positions
   localparam int IC_HIT   = 0;
   localparam int IC_END   = 1;
   localparam int IC_STAT  = 5;
   localparam logic [7:0] VEC_KEEP = 8'hF9;
   localparam logic [7:0] VEC_HIT  = 8'h02;
   localparam logic [7:0] VEC_END  = 8'h04;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } bdma_state_e;
endpackage

// File: rtl/bdma_port.sv
`timescale 1ns/1ps
module bdma_port #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] start_addr,
   input  logic [7:0]    flags,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          is_io
);
   import bdma_pkg::*;

   logic [7:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= '0;
         flags_q <= '0;
      end else if (load) begin
         addr    <= start_addr;
         flags_q <= flags;
      end else if (step && !flags_q[PF_HOLD]) begin
         if (flags_q[PF_UP]) addr <= addr + 1'b1;
         else                addr <= addr - 1'b1;
      end
   end

   assign is_io = flags_q[PF_IO];

   // R3
   start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr == $past(start_addr));
   // R2
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && flags_q[PF_HOLD]) |=> $stable(addr));
   // R2
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !flags_q[PF_HOLD] && flags_q[PF_UP]) |=> addr != $past(addr));
endmodule

// File: rtl/bdma_cmp.sv
`timescale 1ns/1ps
module bdma_cmp #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] pattern,
   input  logic [DW-1:0] mask,
   output logic          hit
);
   logic [DW-1:0] diff;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign diff[i] = (data[i] ^ pattern[i]) & ~mask[i];
   end

   assign hit = ~|diff;

   // R5
   always_comb begin
      if (mask == '1) full_mask_chk: assert (hit);
   end
endmodule

// File: rtl/bdma_count.sv
`timescale 1ns/1ps
module bdma_count #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [CW-1:0] len_in,
   input  logic          bump,
   output logic          done
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic [CW-1:0] cnt_nx;
   logic          wrap;
   logic          reach;

   assign cnt_nx = cnt_q + 1'b1;
   assign wrap   = (cnt_nx == '0);
   assign reach  = (len_q != '0) && (cnt_q >= len_q);
   assign done   = bump && (wrap || reach);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
         len_q <= len_in;
      end else if (bump) begin
         cnt_q <= cnt_nx;
      end
   end

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) |-> ({1'b0, cnt_q} <= ({1'b0, len_q} + 1'b1)));
   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt_q == '0);
endmodule

// File: rtl/bdma_irq.sv
`timescale 1ns/1ps
module bdma_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       fire,
   input  logic       hit,
   input  logic       fin,
   input  logic       ien,
   input  logic [7:0] ictl,
   input  logic [7:0] base,
   output logic       req,
   output logic [7:0] vec
);
   import bdma_pkg::*;

   logic       by_hit;
   logic       by_end;
   logic [7:0] add;

   assign by_hit = hit && ictl[IC_HIT];
   assign by_end = fin && ictl[IC_END];
   assign add    = by_hit ? VEC_HIT : VEC_END;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         vec <= '0;
      end else if (clear) begin
         req <= 1'b0;
         vec <= '0;
      end else if (fire && ien && (by_hit || by_end)) begin
         req <= 1'b1;
         vec <= ictl[IC_STAT] ? ((base & VEC_KEEP) + add) : base;
      end
   end

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !clear) |=> req);
   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(fire && ien));
   // R11
   hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ien && !clear && by_hit && by_end && ictl[IC_STAT]) |=> vec[2:1] == 2'b01);
endmodule

// File: rtl/bdma_engine.sv
`timescale 1ns/1ps
module bdma_engine #(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    ctl,
   input  logic          cont_mode,
   input  logic [7:0]    flags_a,
   input  logic [7:0]    flags_b,
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   input  logic [CW-1:0] blk_len,
   input  logic [DW-1:0] match_pat,
   input  logic [DW-1:0] match_mask,
   input  logic          irq_enable,
   input  logic [7:0]    irq_ctl,
   input  logic [7:0]    irq_base,
   input  logic          service_req,
   output logic [AW-1:0] bus_addr,
   output logic          bus_io,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          busy,
   output logic          match_flag,
   output logic          end_flag,
   output logic          irq_req,
   output logic [7:0]    irq_vec
);
   import bdma_pkg::*;

   localparam int NPORT = 2;

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("bdma_engine: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("bdma_engine: DW must be positive");
   end
   if (CW < 2) begin : g_bad_cw
      $error("bdma_engine: CW must be at least 2");
   end

   bdma_state_e   state_q;
   logic [7:0]    ctl_q;
   logic          cont_q;
   logic [DW-1:0] pat_q, mask_q;
   logic          ien_q;
   logic [7:0]    ictl_q, base_q;
   logic          first_q;
   logic          hit_q;
   logic [DW-1:0] data_q;

   logic          arm, go, step, finish, hit_c, hit_raw, hit_now, cnt_done, stop;
   logic          src_sel, dst_sel;

   logic [AW-1:0] st_addr [NPORT];
   logic [7:0]    st_flag [NPORT];
   logic [AW-1:0] p_addr  [NPORT];
   logic          p_io    [NPORT];

   assign st_addr[0] = addr_a;
   assign st_addr[1] = addr_b;
   assign st_flag[0] = flags_a;
   assign st_flag[1] = flags_b;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      bdma_port #(.AW(AW)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (start),
         .start_addr (st_addr[p]),
         .flags      (st_flag[p]),
         .step       (step),
         .addr       (p_addr[p]),
         .is_io      (p_io[p])
      );
   end

   // port 0 is A, port 1 is B
   assign src_sel = ~ctl_q[CTL_ASRC];
   assign dst_sel = ctl_q[CTL_ASRC];

   assign arm     = start && (ctl[CTL_WR] || ctl[CTL_SRCH]);
   assign go      = !start && (state_q == ST_ARM) && (cont_q || service_req);
   assign step    = go && !first_q;
   assign finish  = !start && (((state_q == ST_RD) && !ctl_q[CTL_WR]) || (state_q == ST_WR));
   assign hit_c   = ctl_q[CTL_SRCH] && hit_raw;
   assign hit_now = (state_q == ST_RD) ? hit_c : hit_q;
   assign stop    = finish && (hit_now || cnt_done);

   bdma_cmp #(.DW(DW)) u_cmp (
      .data    (bus_rdata),
      .pattern (pat_q),
      .mask    (mask_q),
      .hit     (hit_raw)
   );

   bdma_count #(.CW(CW)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .len_in (blk_len),
      .bump   (finish),
      .done   (cnt_done)
   );

   bdma_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .fire  (stop),
      .hit   (hit_now),
      .fin   (cnt_done),
      .ien   (ien_q),
      .ictl  (ictl_q),
      .base  (base_q),
      .req   (irq_req),
      .vec   (irq_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cont_q <= 1'b0;
         pat_q  <= '0;
         mask_q <= '0;
         ien_q  <= 1'b0;
         ictl_q <= '0;
         base_q <= '0;
      end else if (start) begin
         ctl_q  <= ctl;
         cont_q <= cont_mode;
         pat_q  <= match_pat;
         mask_q <= match_mask;
         ien_q  <= irq_enable;
         ictl_q <= irq_ctl;
         base_q <= irq_base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         first_q    <= 1'b1;
         hit_q      <= 1'b0;
         data_q     <= '0;
         match_flag <= 1'b0;
         end_flag   <= 1'b0;
      end else if (start) begin
         state_q    <= arm ? ST_ARM : ST_IDLE;
         first_q    <= 1'b1;
         hit_q      <= 1'b0;
         match_flag <= 1'b0;
         end_flag   <= 1'b0;
      end else begin
         if (finish && hit_now)  match_flag <= 1'b1;
         if (finish && cnt_done) end_flag   <= 1'b1;
         unique case (state_q)
            ST_IDLE: state_q <= ST_IDLE;
            ST_ARM: begin
               if (go) begin
                  state_q <= ST_RD;
                  first_q <= 1'b0;
               end
            end
            ST_RD: begin
               data_q <= bus_rdata;
               hit_q  <= hit_c;
               if (ctl_q[CTL_WR]) state_q <= ST_WR;
               else if (stop)     state_q <= ST_IDLE;
               else               state_q <= ST_ARM;
            end
            ST_WR: state_q <= stop ? ST_IDLE : ST_ARM;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_rd    = (state_q == ST_RD);
      bus_wr    = (state_q == ST_WR);
      bus_addr  = bus_wr ? p_addr[dst_sel] : p_addr[src_sel];
      bus_io    = bus_wr ? p_io[dst_sel]   : p_io[src_sel];
      bus_wdata = data_q;
   end

   assign busy = (state_q != ST_IDLE);

   // R8
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ctl_q[CTL_WR] && !start) |=> bus_wr);
   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (match_flag || end_flag || $past(start)));
   // R7
   byte_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM && !cont_q && !service_req && !start) |=> !bus_rd);
   // R4
   idle_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ctl[CTL_WR] && !ctl[CTL_SRCH]) |=> !busy);
   // R12
   match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !start) |=> match_flag);
   // R12
   end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_flag && !start) |=> end_flag);
endmodule

// File: tb/bdma_engine_test.sv
`timescale 1ns/1ps
module bdma_engine_test;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          start = 0, cont_mode = 1, irq_enable = 1, service_req = 0;
   logic [7:0]    ctl = 0, flags_a = 0, flags_b = 0, irq_ctl = 0, irq_base = 0;
   logic [AW-1:0] addr_a = 0, addr_b = 0;
   logic [CW-1:0] blk_len = 0;
   logic [DW-1:0] match_pat = 0, match_mask = 0;
   logic [AW-1:0] bus_addr;
   logic          bus_io, bus_rd, bus_wr, busy, match_flag, end_flag, irq_req;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic [7:0]    irq_vec;

   bdma_engine #(.AW(AW), .DW(DW), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .cont_mode(cont_mode),
      .flags_a(flags_a), .flags_b(flags_b), .addr_a(addr_a), .addr_b(addr_b),
      .blk_len(blk_len), .match_pat(match_pat), .match_mask(match_mask),
      .irq_enable(irq_enable), .irq_ctl(irq_ctl), .irq_base(irq_base),
      .service_req(service_req), .bus_addr(bus_addr), .bus_io(bus_io),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .match_flag(match_flag), .end_flag(end_flag),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   // bus model: memory holds its low address byte, I/O holds the inverse
   logic [7:0] mem_m [256];
   logic [7:0] io_m  [256];
   logic       mem_init = 0;
   int         rd_n, wr_n;
   logic [15:0] last_addr;
   logic [7:0]  last_data;
   logic        last_io;

   assign bus_rdata = bus_io ? io_m[bus_addr[7:0]] : mem_m[bus_addr[7:0]];

   always @(posedge clk) begin
      if (mem_init) begin
         for (int i = 0; i < 256; i++) begin
            mem_m[i] <= 8'(i);
            io_m[i]  <= ~8'(i);
         end
         rd_n <= 0; wr_n <= 0; last_addr <= '0; last_data <= '0; last_io <= 1'b0;
      end else begin
         if (bus_rd) begin
            rd_n <= rd_n + 1; last_addr <= bus_addr; last_data <= bus_rdata; last_io <= bus_io;
         end
         if (bus_wr) begin
            wr_n <= wr_n + 1; last_addr <= bus_addr; last_data <= bus_wdata; last_io <= bus_io;
            if (bus_io) io_m[bus_addr[7:0]] <= bus_wdata;
            else        mem_m[bus_addr[7:0]] <= bus_wdata;
         end
      end
   end

   int checks = 0;
   int failures = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [7:0] c, fa, fb, input logic [15:0] sa, sb,
                         input logic [7:0] ln, pt, mk, ic, ib, input logic cm, ie);
      @(negedge clk);
      ctl = c; flags_a = fa; flags_b = fb; addr_a = sa; addr_b = sb; blk_len = ln;
      match_pat = pt; match_mask = mk; irq_ctl = ic; irq_base = ib;
      cont_mode = cm; irq_enable = ie; mem_init = 1;
      @(negedge clk);
      mem_init = 0; start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk("R8 busy falls at stop", 32'(busy), 32'd0);
   endtask

   typedef struct packed {
      logic [7:0]  ctl, fa, fb;
      logic [15:0] sa, sb;
      logic [7:0]  len, pat, msk, ict, ivb;
      logic [15:0] e_rd, e_wr, e_addr;
      logic [7:0]  e_data;
      logic        e_io, e_match, e_end, e_irq;
      logic [7:0]  e_vec;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t TBL [NV] = '{
      // R1 R2 R6: A->B, both mem up, len 3 -> 4 bytes
      '{8'h05, 8'h10, 8'h10, 16'h0010, 16'h0080, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00,
        16'd4, 16'd4, 16'h0083, 8'h13, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
      // R1 R2: B->A, B mem down, A fixed I/O
      '{8'h01, 8'h28, 8'h00, 16'h0040, 16'h0020, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00,
        16'd3, 16'd3, 16'h0040, 8'h1E, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
      // R5 R10: search only, hit on 6th byte, status vector
      '{8'h06, 8'h10, 8'h10, 16'h0030, 16'h0090, 8'h14, 8'h35, 8'h00, 8'h21, 8'hFF,
        16'd6, 16'd0, 16'h0035, 8'h35, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFB},
      // R5 R10: masked hit on first byte, still written to I/O, plain vector
      '{8'h07, 8'h10, 8'h18, 16'h0050, 16'h0000, 8'h0A, 8'h5C, 8'h0F, 8'h01, 8'h40,
        16'd1, 16'd1, 16'h0000, 8'h50, 1'b1, 1'b1, 1'b0, 1'b1, 8'h40},
      // R2 R10: fixed source, dest down, end vector
      '{8'h05, 8'h20, 8'h00, 16'h0077, 16'h0090, 8'h01, 8'h00, 8'h00, 8'h22, 8'h13,
        16'd2, 16'd2, 16'h008F, 8'h77, 1'b0, 1'b0, 1'b1, 1'b1, 8'h15},
      // R11: hit and end on same byte
      '{8'h07, 8'h10, 8'h10, 16'h0010, 16'h00A0, 8'h02, 8'h12, 8'h00, 8'h23, 8'h80,
        16'd3, 16'd3, 16'h00A2, 8'h12, 1'b0, 1'b1, 1'b1, 1'b1, 8'h82},
      // R5: partial mask, hit at 0x5C
      '{8'h06, 8'h10, 8'h10, 16'h0050, 16'h0000, 8'h0F, 8'h5C, 8'h03, 8'h00, 8'h00,
        16'd13, 16'd0, 16'h005C, 8'h5C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}
   };

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R8 reset busy", 32'(busy), 0);
      chk("R8 reset rd", 32'(bus_rd), 0);
      chk("R8 reset wr", 32'(bus_wr), 0);
      chk("R12 reset flags", {30'd0, match_flag, end_flag}, 0);
      chk("R9 reset irq", 32'(irq_req), 0);

      for (int i = 0; i < NV; i++) begin
         v = TBL[i];
         launch(v.ctl, v.fa, v.fb, v.sa, v.sb, v.len, v.pat, v.msk, v.ict, v.ivb, 1'b1, 1'b1);
         wait_idle();
         chk("R6 read count", 32'(rd_n), 32'(v.e_rd));
         chk("R4 write count", 32'(wr_n), 32'(v.e_wr));
         chk("R1 last address", 32'(last_addr), 32'(v.e_addr));
         chk("R1 last data", 32'(last_data), 32'(v.e_data));
         chk("R2 last space", 32'(last_io), 32'(v.e_io));
         chk("R5 match flag", 32'(match_flag), 32'(v.e_match));
         chk("R6 end flag", 32'(end_flag), 32'(v.e_end));
         chk("R9 irq", 32'(irq_req), 32'(v.e_irq));
         chk("R10 vector", 32'(irq_vec), 32'(v.e_vec));
      end

      // R9 sticky request, then R12 restart clears everything
      repeat (4) @(negedge clk);
      chk("R12 flags held", {30'd0, match_flag, end_flag}, 32'd2);
      chk("R9 irq held", 32'(irq_req), 0);
      launch(8'h05, 8'h20, 8'h00, 16'h0077, 16'h0090, 8'h01, 8'h00, 8'h00, 8'h22, 8'h13, 1'b1, 1'b0);
      wait_idle();
      chk("R9 irq masked by irq_enable", 32'(irq_req), 0);
      chk("R9 end still flagged", 32'(end_flag), 1);

      // R4 neither action enabled
      launch(8'h00, 8'h10, 8'h10, 16'h0010, 16'h0020, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
      repeat (6) @(negedge clk);
      chk("R4 idle busy", 32'(busy), 0);
      chk("R4 idle no reads", 32'(rd_n), 0);
      chk("R12 flags cleared by start", {30'd0, match_flag, end_flag}, 0);

      // R6 counter wrap with zero length: 2^CW bytes
      launch(8'h01, 8'h20, 8'h20, 16'h0001, 16'h0002, 8'h00, 8'h00, 8'h00, 8'h02, 8'h30, 1'b1, 1'b1);
      wait_idle();
      chk("R6 wrap byte count", 32'(wr_n), 32'd256);
      chk("R6 wrap end flag", 32'(end_flag), 1);
      chk("R10 plain end vector", 32'(irq_vec), 32'h30);

      // R7 byte mode, R3 deferred first step
      launch(8'h05, 8'h10, 8'h10, 16'h0010, 16'h0080, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk("R7 waits for request", 32'(rd_n), 0);
      chk("R7 busy while waiting", 32'(busy), 1);
      service_req = 1;
      @(negedge clk);
      service_req = 0;
      repeat (3) @(negedge clk);
      chk("R7 one byte per request rd", 32'(rd_n), 1);
      chk("R7 one byte per request wr", 32'(wr_n), 1);
      chk("R3 first byte unstepped addr", 32'(last_addr), 32'h0080);
      chk("R3 first byte data", 32'(last_data), 32'h10);
      service_req = 1;
      @(negedge clk);
      service_req = 0;
      repeat (3) @(negedge clk);
      chk("R7 second request", 32'(wr_n), 2);
      chk("R3 stepped addr", 32'(last_addr), 32'h0081);
      chk("R3 stepped data", 32'(last_data), 32'h11);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule